// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a CPU data-memory port and an 8-bit multiplexed external bus. The low address byte and the data share one bidirectional byte lane. The high address byte has a port of its own. An address-latch-enable strobe marks the address phase, and active-low read and write strobes mark the data phase. On each request the controller compares the address with a parameterised internal SRAM boundary and flags the access as internal or external. It then runs the bus sequence and holds the CPU with a busy/ready handshake until the access is complete.

While the interface is enabled, it takes over the direction settings of the pins it owns. Every access, internal or external, runs the full sequence. The sequence is an address phase with the latch strobe high, then a setup cycle, then a strobe phase of 1 + N cycles, then a hold cycle in which the CPU sees ready. N is a wait count from 0 to 3, taken when the request is accepted. On an internal access the read and write strobes stay idle. While the interface is disabled, a request completes in one cycle. There is no bus activity, and an address above the boundary is never flagged as internal.

Top module: `xmem_ctrl`

## Requirements
- R1: `int_sel_o` is high in every cycle of an access whose captured address is at or below `INT_TOP` (default 0x025F). It is low for higher addresses and low while idle.
- R2: With the interface enabled, the first cycle after a request is accepted drives `ale_o`=1 and `ad_oe_o`=1, with `ad_o` equal to the address bits [7:0].
- R3: `ale_o` is low in every later cycle of the access. A strobe is never low while `ale_o` is high.
- R4: An internal access with the interface enabled runs the same address, setup, strobe and hold cycles, including the `ale_o` and AD activity. `rd_no` and `wr_no` stay high throughout.
- R5: `pin_ovr_o` equals `en_i`.
- R6: With the interface disabled, `ready_o` is high in the first cycle after acceptance. In that cycle `ale_o`=0 and `ad_oe_o`=0, and both strobes are high.
- R7: `ahi_o` equals address bits [15:8] in every cycle of an access.
- R8: On an external access, the strobe (`rd_no` for reads, `wr_no` for writes) is low from the third cycle after acceptance for exactly 1+N cycles. N is `wait_i` as sampled at acceptance. The other strobe stays high.
- R9: On a read, `ad_oe_o` is low from the second cycle onward. `rdata_o` takes the value of `ad_i` from the last strobe cycle of an external read. Internal reads and all writes leave `rdata_o` unchanged.
- R10: On a write, `ad_oe_o`=1 and `ad_o` equals the write data from the second cycle through the hold cycle that follows the rise of `wr_no`.
- R11: `ready_o` is a one-cycle pulse in cycle 3+N after acceptance (counting from 0). `busy_o` is high from acceptance through that cycle. A request that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| wait_i | input | 2 | Wait-state count N |
| req_i | input | 1 | CPU access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| ready_o | output | 1 | Access complete pulse |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 8 | Last external read data |
| int_sel_o | output | 1 | Current access targets internal SRAM |
| pin_ovr_o | output | 1 | Pin direction override for owned ports |
| ad_o | output | 8 | Multiplexed address/data out |
| ad_i | input | 8 | Multiplexed data in |
| ad_oe_o | output | 1 | AD output enable |
| ahi_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach from the ports is the sampling instant of read data. The bus value must be taken in the last strobe cycle and in no other. The bench therefore drives the complement of the expected byte on `ad_i` in every cycle except the computed last strobe cycle, for each wait count. A second hard case is a request that arrives mid-access and carries a different address and wait count. The bench raises such a request during the setup cycle and then checks that the high address, the strobe length and the idle cycle that follows are unaffected.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SETUP, ST_STRB, ST_HOLD, ST_RESP
  } xm_state_e;
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode #(
  parameter int          AW      = 16,
  parameter logic [15:0] INT_TOP = 16'h025F
) (
  input  logic [AW-1:0] addr_i,
  output logic          is_int_o
);
  localparam logic [AW-1:0] TopL = AW'(INT_TOP);
  assign is_int_o = (addr_i <= TopL);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int WW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [WW-1:0] wait_i,
  input  logic          is_int_i,
  output xm_state_e     st_o,
  output logic          last_o,
  output logic [AW-1:0] addr_q_o,
  output logic [DW-1:0] wdata_q_o,
  output logic          we_q_o,
  output logic          int_q_o
);
  xm_state_e     st_q;
  logic [WW-1:0] wcnt_q, wlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wcnt_q    <= '0;
      wlim_q    <= '0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      we_q_o    <= 1'b0;
      int_q_o   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          addr_q_o  <= addr_i;
          wdata_q_o <= wdata_i;
          we_q_o    <= we_i;
          int_q_o   <= is_int_i;
          wlim_q    <= wait_i;
          st_q      <= en_i ? ST_ADDR : ST_RESP;
        end
        ST_ADDR:  st_q <= ST_SETUP;
        ST_SETUP: begin
          wcnt_q <= '0;
          st_q   <= ST_STRB;
        end
        ST_STRB: begin
          if (wcnt_q == wlim_q) st_q <= ST_HOLD;
          else                  wcnt_q <= wcnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign last_o = (st_q == ST_STRB) && (wcnt_q == wlim_q);

  // R11: a request while busy must not disturb the captured access
  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(addr_q_o) && $stable(we_q_o));
  // R8: wait counter never passes its captured limit
  p_wait_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STRB) |-> (wcnt_q <= wlim_q));
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  xm_state_e     st_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_q_i,
  input  logic [DW-1:0] wdata_q_i,
  input  logic          we_q_i,
  input  logic          int_q_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] ahi_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          busy_o,
  output logic          int_sel_o,
  output logic          pin_ovr_o
);
  logic data_ph, strb_act;

  assign data_ph   = (st_i == ST_SETUP) || (st_i == ST_STRB) || (st_i == ST_HOLD);
  assign ale_o     = (st_i == ST_ADDR);
  assign ad_o      = ale_o ? addr_q_i[DW-1:0] : wdata_q_i;
  assign ad_oe_o   = ale_o || (we_q_i && data_ph);
  assign ahi_o     = addr_q_i[AW-1:DW];
  assign strb_act  = (st_i == ST_STRB) && !int_q_i;
  assign rd_no     = !(strb_act && !we_q_i);
  assign wr_no     = !(strb_act && we_q_i);
  assign ready_o   = (st_i == ST_HOLD) || (st_i == ST_RESP);
  assign busy_o    = (st_i != ST_IDLE);
  assign int_sel_o = busy_o && int_q_i;
  assign pin_ovr_o = en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= '0;
    else if (last_i && !int_q_i && !we_q_i) rdata_o <= ad_i;
  end

  p_ale_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> $past(ad_oe_o));
  p_strb_ale_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !ale_o);
  p_int_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> (rd_no && wr_no));
  p_dis_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RESP) |-> (!ale_o && !ad_oe_o && rd_no && wr_no));
  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));
  p_rd_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> ad_oe_o);
  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter int          WW      = 2,
  parameter logic [15:0] INT_TOP = 16'h025F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [WW-1:0] wait_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          int_sel_o,
  output logic          pin_ovr_o,
  output logic [DW-1:0] ad_o,
  input  logic [DW-1:0] ad_i,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] ahi_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no
);
  xm_state_e     st;
  logic          last, is_int, we_q, int_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  xmem_decode #(.AW(AW), .INT_TOP(INT_TOP)) u_decode (
    .addr_i(addr_i), .is_int_o(is_int));

  xmem_seq #(.AW(AW), .DW(DW), .WW(WW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wait_i(wait_i), .is_int_i(is_int),
    .st_o(st), .last_o(last), .addr_q_o(addr_q), .wdata_q_o(wdata_q),
    .we_q_o(we_q), .int_q_o(int_q));

  xmem_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .st_i(st), .last_i(last),
    .addr_q_i(addr_q), .wdata_q_i(wdata_q), .we_q_i(we_q), .int_q_i(int_q),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ahi_o(ahi_o), .ale_o(ale_o),
    .rd_no(rd_no), .wr_no(wr_no), .rdata_o(rdata_o), .ready_o(ready_o),
    .busy_o(busy_o), .int_sel_o(int_sel_o), .pin_ovr_o(pin_ovr_o));
endmodule

// File: tb/xmem_ctrl_tb.sv
module xmem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TOP = 16'h025F;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  wait_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, ad_i = '0;
  logic        ready_o, busy_o, int_sel_o, pin_ovr_o, ad_oe_o, ale_o, rd_no, wr_no;
  logic [7:0]  rdata_o, ad_o, ahi_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_rdata = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xmem_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wait_i(wait_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o),
    .busy_o(busy_o), .rdata_o(rdata_o), .int_sel_o(int_sel_o),
    .pin_ovr_o(pin_ovr_o), .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o),
    .ahi_o(ahi_o), .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_access(input bit en, input logic [1:0] wt, input bit we,
                           input logic [15:0] addr, input logic [7:0] wd, input bit poke);
    bit   is_int = (addr <= TOP);
    bit   ext    = !is_int;
    int   n      = int'(wt);
    logic [7:0] good = addr[7:0] ^ {6'b0, wt} ^ 8'h3C;
    @(negedge clk_i);
    en_i = en; wait_i = wt; we_i = we; addr_i = addr; wdata_i = wd;
    req_i = 1'b1; ad_i = ~good;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    check("R5 override", pin_ovr_o, en);
    if (!en) begin
      check("R6 ready", ready_o, 1'b1);
      check("R6 quiet", {ale_o, ad_oe_o, rd_no, wr_no}, 4'b0011);
      check("R1 int_sel", int_sel_o, is_int);
      check("R7 ahi", ahi_o, addr[15:8]);
      @(negedge clk_i);
      check("R11 idle after", {ready_o, busy_o}, 2'b00);
    end else begin
      for (int c = 0; c <= 3 + n; c++) begin
        if (poke && c == 1) begin req_i = 1'b1; addr_i = 16'hBEEF; wait_i = 2'd3; end
        if (poke && c == 2) req_i = 1'b0;
        check("R7 ahi", ahi_o, addr[15:8]);
        check("R1 int_sel", int_sel_o, is_int);
        check("R11 busy", busy_o, 1'b1);
        check("R11 ready", ready_o, (c == 3 + n));
        if (c == 0) begin
          check("R2 addr phase", {ale_o, ad_oe_o, ad_o}, {2'b11, addr[7:0]});
          check("R3 no strobe", {rd_no, wr_no}, 2'b11);
        end else begin
          check("R3 ale low", ale_o, 1'b0);
          check("R9 R10 ad_oe", ad_oe_o, we);
          if (we) check("R10 wdata", ad_o, wd);
          if (c >= 2 && c <= 2 + n) begin
            check("R8 R4 rd_n", rd_no, !(ext && !we));
            check("R8 R4 wr_n", wr_no, !(ext && we));
            if (c == 2 + n) ad_i = good;
          end else begin
            check("R8 strobes idle", {rd_no, wr_no}, 2'b11);
          end
          if (c == 3 + n) ad_i = ~good;
        end
        @(negedge clk_i);
      end
      if (ext && !we) exp_rdata = good;
      check("R11 done", {ready_o, busy_o, ale_o}, 3'b000);
      check("R9 rdata", rdata_o, exp_rdata);
    end
  endtask

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = 16'h0010; addrs[1] = TOP; addrs[2] = TOP + 16'h1; addrs[3] = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    check("R11 reset ready/busy", {ready_o, busy_o}, 2'b00);
    check("R3 reset pins", {ale_o, ad_oe_o, rd_no, wr_no}, 4'b0011);
    check("R1 reset int_sel", int_sel_o, 1'b0);
    check("R9 reset rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 4; w++)
        for (int r = 0; r < 2; r++)
          for (int a = 0; a < 4; a++)
            do_access(e[0], w[1:0], r[0], addrs[a],
                      addrs[a][7:0] ^ {w[1:0], r[0], 5'h15}, 1'b0);
    // R11/R8: requests mid-access ignored, wait count held from acceptance
    do_access(1'b1, 2'd1, 1'b0, 16'h8123, 8'h00, 1'b1);
    do_access(1'b1, 2'd0, 1'b1, 16'h4A55, 8'hC3, 1'b1);
    do_access(1'b1, 2'd2, 1'b0, 16'h0100, 8'h00, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule